// File: doc/BRIEF.md
# UART Transmitter with Flow Control

This block turns bytes handed over on a ready/valid input into asynchronous serial frames on a single output line. A frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. The line rests high whenever no frame is running. Bit timing comes from an external one-cycle baud enable, `baudTick`, which pulses once per bit interval. Every frame starts on a tick, and every bit lasts exactly one tick interval.

Two pause mechanisms decide whether a new frame may begin. The first is a clear-to-send handshake input, used when `ctsEn` is set. The second is software flow control, used when `swFlowEn` is set. A companion receiver reports decoded pause (XOFF) and resume (XON) characters as one-cycle pulses, and the block keeps the resulting pause state. Pausing only blocks frame starts, so a frame that is already on the line always runs to its stop bit.

The local side can ask for an XON (0x11) or XOFF (0x13) character to be sent. Such a request goes out ahead of any queued data. The software pause does not block it, but the clear-to-send handshake still does.

Top module: `uart_flow_tx`

## Requirements
- R1: After reset and between frames `txLine` is high, and the block starts in the resumed (not paused) state.
- R2: A frame is a low start bit, then DATA_BITS data bits least significant first, then a high stop bit. Each bit lasts one `baudTick` interval, and the frame's first bit appears on the cycle after the tick that starts it.
- R3: With `parityEn` high, one parity bit follows the most significant data bit. With `parityOdd` low it is the XOR of the data bits (even parity). With `parityOdd` high it is the inverse of that XOR (odd parity).
- R4: With `ctsEn` high, no frame starts while `cts` is low. A pending byte goes out once `cts` rises.
- R5: With `ctsEn` low, the level of `cts` has no effect on frame starts.
- R6: With `swFlowEn` high, an `rxXoffSeen` pulse stops new data frames from starting until an `rxXonSeen` pulse arrives. If both pulse in the same cycle, the block resumes.
- R7: A pause that arrives while a frame is on the line does not cut that frame. The frame completes with a valid stop bit, and the next data frame is held.
- R8: A `sendXon` pulse queues the character 0x11 and a `sendXoff` pulse queues 0x13. A queued character is sent before any data byte offered at the same time.
- R9: Queued XON/XOFF characters are sent while the software pause is active, but they still wait for `cts` when `ctsEn` is high.
- R10: With `swFlowEn` low, `rxXoffSeen` has no effect on data frames.
- R11: When both characters are queued, 0x13 is sent first and 0x11 follows.
- R12: Each accepted handshake (`inValid` and `inReady` high in one cycle) produces exactly one frame, in acceptance order. `inReady` is high only when no frame is running and `baudTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse per bit interval |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| ctsEn | input | 1 | Enable the clear-to-send gate |
| cts | input | 1 | Clear to send; high permits frame starts |
| swFlowEn | input | 1 | Enable the XOFF/XON pause |
| rxXoffSeen | input | 1 | Pulse: the receiver decoded XOFF |
| rxXonSeen | input | 1 | Pulse: the receiver decoded XON |
| sendXon | input | 1 | Pulse: request an outgoing XON character |
| sendXoff | input | 1 | Pulse: request an outgoing XOFF character |
| inData | input | DATA_BITS | Byte to send |
| inValid | input | 1 | inData is valid |
| inReady | output | 1 | Block accepts inData this cycle |
| txLine | output | 1 | Serial output line |

## Verification
A corrupted pause flag or pending-request flag shows up as a frame that starts when it should not, or never starts. That difference appears at `inReady` and `txLine` on the next baud tick after the bad state arises. A wrong bit count or a bad shift register shows up inside the frame itself, as a misplaced stop bit, a wrong parity bit or a low line between frames. It becomes visible within one frame of about DATA_BITS+3 tick intervals. The directed scenarios decode every frame at the mid-point of each bit. They also watch for frames that appear while a pause should hold the line idle.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam logic [7:0] XON_CODE  = 8'h11;
  localparam logic [7:0] XOFF_CODE = 8'h13;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_XON  = 2'd1,
    SRC_XOFF = 2'd2
  } uft_src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;     // start a new frame this cycle
    logic     advance;  // step to the next bit
    uft_src_e src;      // which byte the frame carries
  } uft_strobe_t;

endpackage

// File: rtl/uft_datapath.sv
module uft_datapath
  import uft_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uft_strobe_t          strobe,
  input  logic [DATA_BITS-1:0] dataIn,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  output logic                 frameActive,
  output logic                 txLine
);

  localparam int FRAME_W = DATA_BITS + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_PAR   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [DATA_BITS-1:0] byteSel;
  logic                 parBit;
  logic [FRAME_W-1:0]   frameImg;
  logic [FRAME_W-1:0]   shiftQ;
  logic [CNT_W-1:0]     leftQ;
  logic                 activeQ;

  always_comb begin
    case (strobe.src)
      SRC_XON:  byteSel = DATA_BITS'(XON_CODE);
      SRC_XOFF: byteSel = DATA_BITS'(XOFF_CODE);
      default:  byteSel = dataIn;
    endcase
  end

  assign parBit = parityOdd ? ~(^byteSel) : (^byteSel);

  // frame image, bit 0 leaves first
  always_comb begin
    frameImg[0]             = 1'b0;
    frameImg[DATA_BITS:1]   = byteSel;
    frameImg[DATA_BITS+1]   = parityEn ? parBit : 1'b1;
    frameImg[DATA_BITS+2]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '1;
      leftQ   <= '0;
      activeQ <= 1'b0;
    end else if (strobe.load) begin
      shiftQ  <= frameImg;
      leftQ   <= parityEn ? LEN_PAR : LEN_PLAIN;
      activeQ <= 1'b1;
    end else if (strobe.advance) begin
      shiftQ <= {1'b1, shiftQ[FRAME_W-1:1]};
      leftQ  <= leftQ - ONE;
      if (leftQ == ONE) activeQ <= 1'b0;
    end
  end

  assign frameActive = activeQ;
  assign txLine      = activeQ ? shiftQ[0] : 1'b1;

endmodule

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baudTick,
  input  logic        ctsEn,
  input  logic        cts,
  input  logic        swFlowEn,
  input  logic        rxXoffSeen,
  input  logic        rxXonSeen,
  input  logic        sendXon,
  input  logic        sendXoff,
  input  logic        inValid,
  input  logic        frameActive,
  output logic        inReady,
  output uft_strobe_t strobe
);

  logic pausedQ;
  logic xonPendQ;
  logic xoffPendQ;
  logic ctsOk;
  logic pauseOn;
  logic slotFree;
  logic ctrlPend;
  logic loadCtrl;
  logic loadData;
  uft_src_e srcSel;

  assign ctsOk    = !ctsEn || cts;
  assign pauseOn  = swFlowEn && pausedQ;
  assign slotFree = !frameActive && baudTick && ctsOk;
  assign ctrlPend = xonPendQ || xoffPendQ;

  assign loadCtrl = slotFree && ctrlPend;
  assign inReady  = slotFree && !ctrlPend && !pauseOn;
  assign loadData = inReady && inValid;

  always_comb begin
    if (xoffPendQ)     srcSel = SRC_XOFF;
    else if (xonPendQ) srcSel = SRC_XON;
    else               srcSel = SRC_DATA;
  end

  always_comb begin
    strobe.load    = loadCtrl || loadData;
    strobe.advance = frameActive && baudTick;
    strobe.src     = srcSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pausedQ   <= 1'b0;
      xonPendQ  <= 1'b0;
      xoffPendQ <= 1'b0;
    end else begin
      if (rxXonSeen)       pausedQ <= 1'b0;
      else if (rxXoffSeen) pausedQ <= 1'b1;

      xoffPendQ <= sendXoff || (xoffPendQ && !(loadCtrl && srcSel == SRC_XOFF));
      xonPendQ  <= sendXon  || (xonPendQ  && !(loadCtrl && srcSel == SRC_XON));
    end
  end

endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
  import uft_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 ctsEn,
  input  logic                 cts,
  input  logic                 swFlowEn,
  input  logic                 rxXoffSeen,
  input  logic                 rxXonSeen,
  input  logic                 sendXon,
  input  logic                 sendXoff,
  input  logic [DATA_BITS-1:0] inData,
  input  logic                 inValid,
  output logic                 inReady,
  output logic                 txLine
);

  uft_strobe_t strobe;
  logic        frameActive;

  uft_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .ctsEn       (ctsEn),
    .cts         (cts),
    .swFlowEn    (swFlowEn),
    .rxXoffSeen  (rxXoffSeen),
    .rxXonSeen   (rxXonSeen),
    .sendXon     (sendXon),
    .sendXoff    (sendXoff),
    .inValid     (inValid),
    .frameActive (frameActive),
    .inReady     (inReady),
    .strobe      (strobe)
  );

  uft_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dataIn      (inData),
    .parityEn    (parityEn),
    .parityOdd   (parityOdd),
    .frameActive (frameActive),
    .txLine      (txLine)
  );

endmodule

// File: rtl/uft_checker.sv
module uft_checker
  import uft_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        baudTick,
  input logic        ctsEn,
  input logic        cts,
  input logic        swFlowEn,
  input logic        rxXoffSeen,
  input logic        rxXonSeen,
  input logic        inValid,
  input logic        inReady,
  input logic        txLine,
  input logic        frameActive,
  input uft_strobe_t strobe
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> txLine);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !txLine);

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !baudTick) |=> $stable(txLine));

  p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && ctsEn) |-> cts);

  p_xoff_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (swFlowEn && $past(rstN) && $past(swFlowEn && rxXoffSeen && !rxXonSeen)) |-> !inReady);

  p_no_cut_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !baudTick) |=> frameActive);

  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!frameActive && baudTick));

  p_one_frame_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !frameActive);

  // R12: a load outside the idle state would be flagged above; also no accept without valid
  p_accept_loads_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> strobe.load);

endmodule

bind uart_flow_tx uft_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .baudTick    (baudTick),
  .ctsEn       (ctsEn),
  .cts         (cts),
  .swFlowEn    (swFlowEn),
  .rxXoffSeen  (rxXoffSeen),
  .rxXonSeen   (rxXonSeen),
  .inValid     (inValid),
  .inReady     (inReady),
  .txLine      (txLine),
  .frameActive (frameActive),
  .strobe      (strobe)
);

// File: tb/uart_flow_tx_bench.sv
`timescale 1ns/1ps
module uart_flow_tx_bench;

  localparam int DW   = 8;
  localparam int TICK = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          baudTick;
  logic          parityEn = 1'b0, parityOdd = 1'b0;
  logic          ctsEn = 1'b0, cts = 1'b1, swFlowEn = 1'b1;
  logic          rxXoffSeen = 1'b0, rxXonSeen = 1'b0;
  logic          sendXon = 1'b0, sendXoff = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inValid = 1'b0;
  logic          inReady, txLine;

  uart_flow_tx #(.DATA_BITS(DW)) u_uart_flow_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .parityEn(parityEn), .parityOdd(parityOdd),
    .ctsEn(ctsEn), .cts(cts), .swFlowEn(swFlowEn),
    .rxXoffSeen(rxXoffSeen), .rxXonSeen(rxXonSeen),
    .sendXon(sendXon), .sendXoff(sendXoff),
    .inData(inData), .inValid(inValid),
    .inReady(inReady), .txLine(txLine)
  );

  int tickCnt = 0;
  always @(negedge clk) tickCnt = (tickCnt == TICK - 1) ? 0 : tickCnt + 1;
  assign baudTick = (tickCnt == TICK - 1);

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // frame monitor: samples each bit at its centre
  logic [DW-1:0] capData[$];
  logic          capPar[$];
  logic          capOk[$];
  logic          monBusy = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txLine === 1'b0) begin
        logic [DW-1:0] d;
        logic sb, pb, eb;
        monBusy = 1'b1;
        @(negedge clk);
        sb = txLine;
        for (int k = 0; k < DW; k++) begin
          repeat (TICK) @(negedge clk);
          d[k] = txLine;
        end
        pb = 1'b0;
        if (parityEn) begin
          repeat (TICK) @(negedge clk);
          pb = txLine;
        end
        repeat (TICK) @(negedge clk);
        eb = txLine;
        capData.push_back(d);
        capPar.push_back(pb);
        capOk.push_back(!sb && eb);
        monBusy = 1'b0;
      end
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic pushByte(input logic [DW-1:0] b);
    @(negedge clk);
    inData  = b;
    inValid = 1'b1;
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitFrames(input int n);
    int guard = 0;
    while ((capData.size() < n || monBusy) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expectFrame(input int idx, input logic [DW-1:0] exp, input string req);
    if (idx < capData.size()) begin
      check(capData[idx] == exp, req, "frame data", capData[idx], exp);
      check(capOk[idx] == 1'b1, req, "start/stop bits", capOk[idx], 1);
    end else begin
      check(1'b0, req, "frame missing", capData.size(), idx + 1);
    end
  endtask

  task automatic t_reset_r1();
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R1", "line during reset", txLine, 1);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(txLine === 1'b1, "R1", "line idle after reset", txLine, 1);
    check(capData.size() == 0, "R1", "no frame after reset", capData.size(), 0);
  endtask

  task automatic t_basic_r2();
    int b = capData.size();
    pushByte(8'hA5);
    waitFrames(b + 1);
    expectFrame(b, 8'hA5, "R2");
    pushByte(8'h01);
    waitFrames(b + 2);
    expectFrame(b + 1, 8'h01, "R2");
    check(txLine === 1'b1, "R1", "line idle between frames", txLine, 1);
  endtask

  task automatic t_parity_r3();
    int b = capData.size();
    parityEn = 1'b1; parityOdd = 1'b0;
    pushByte(8'h07);
    waitFrames(b + 1);
    expectFrame(b, 8'h07, "R3");
    check(capPar[b] == 1'b1, "R3", "even parity of 0x07", capPar[b], 1);
    parityOdd = 1'b1;
    pushByte(8'h03);
    waitFrames(b + 2);
    expectFrame(b + 1, 8'h03, "R3");
    check(capPar[b + 1] == 1'b1, "R3", "odd parity of 0x03", capPar[b + 1], 1);
    pushByte(8'h07);
    waitFrames(b + 3);
    check(capPar[b + 2] == 1'b0, "R3", "odd parity of 0x07", capPar[b + 2], 0);
    parityEn = 1'b0; parityOdd = 1'b0;
  endtask

  task automatic t_cts_r4();
    int b = capData.size();
    ctsEn = 1'b1; cts = 1'b0;
    fork pushByte(8'h5C); join_none
    repeat (120) @(negedge clk);
    check(capData.size() == b && txLine === 1'b1, "R4", "held while cts low",
          capData.size(), b);
    cts = 1'b1;
    waitFrames(b + 1);
    expectFrame(b, 8'h5C, "R4");
    ctsEn = 1'b0;
  endtask

  task automatic t_cts_off_r5();
    int b = capData.size();
    ctsEn = 1'b0; cts = 1'b0;
    pushByte(8'h3E);
    waitFrames(b + 1);
    expectFrame(b, 8'h3E, "R5");
    cts = 1'b1;
  endtask

  task automatic t_xoff_r6();
    int b = capData.size();
    pulse(rxXoffSeen);
    fork pushByte(8'h77); join_none
    repeat (120) @(negedge clk);
    check(capData.size() == b, "R6", "data held after XOFF", capData.size(), b);
    pulse(rxXonSeen);
    waitFrames(b + 1);
    expectFrame(b, 8'h77, "R6");
    // both pulses together resume
    @(negedge clk); rxXoffSeen = 1'b1; rxXonSeen = 1'b1;
    @(negedge clk); rxXoffSeen = 1'b0; rxXonSeen = 1'b0;
    pushByte(8'h12);
    waitFrames(b + 2);
    expectFrame(b + 1, 8'h12, "R6");
  endtask

  task automatic t_midframe_r7();
    int b = capData.size();
    pushByte(8'h5A);
    fork pushByte(8'hC3); join_none
    repeat (12) @(negedge clk);
    pulse(rxXoffSeen);
    repeat (150) @(negedge clk);
    check(capData.size() == b + 1, "R7", "only running frame completes",
          capData.size(), b + 1);
    expectFrame(b, 8'h5A, "R7");
    pulse(rxXonSeen);
    waitFrames(b + 2);
    expectFrame(b + 1, 8'hC3, "R7");
  endtask

  task automatic t_ctrl_first_r8();
    int b = capData.size();
    @(negedge clk);
    inData = 8'h44; inValid = 1'b1;
    while (baudTick) @(negedge clk);
    pulse(sendXon);
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
    end
    @(negedge clk); inValid = 1'b0;
    waitFrames(b + 2);
    expectFrame(b, 8'h11, "R8");
    expectFrame(b + 1, 8'h44, "R8");
  endtask

  task automatic t_ctrl_paused_r9();
    int b = capData.size();
    pulse(rxXoffSeen);
    pulse(sendXon);
    waitFrames(b + 1);
    expectFrame(b, 8'h11, "R9");
    ctsEn = 1'b1; cts = 1'b0;
    pulse(sendXoff);
    repeat (120) @(negedge clk);
    check(capData.size() == b + 1, "R9", "control char waits for cts",
          capData.size(), b + 1);
    cts = 1'b1;
    waitFrames(b + 2);
    expectFrame(b + 1, 8'h13, "R9");
    ctsEn = 1'b0;
    pulse(rxXonSeen);
  endtask

  task automatic t_swoff_r10();
    int b = capData.size();
    swFlowEn = 1'b0;
    pulse(rxXoffSeen);
    pushByte(8'h99);
    waitFrames(b + 1);
    expectFrame(b, 8'h99, "R10");
    pulse(rxXonSeen);
    swFlowEn = 1'b1;
  endtask

  task automatic t_both_r11();
    int b = capData.size();
    @(negedge clk);
    while (baudTick) @(negedge clk);
    sendXon = 1'b1; sendXoff = 1'b1;
    @(negedge clk); sendXon = 1'b0; sendXoff = 1'b0;
    waitFrames(b + 2);
    expectFrame(b, 8'h13, "R11");
    expectFrame(b + 1, 8'h11, "R11");
  endtask

  task automatic t_handshake_r12();
    int b = capData.size();
    pushByte(8'hF0);
    pushByte(8'h0F);
    pushByte(8'h80);
    waitFrames(b + 3);
    repeat (60) @(negedge clk);
    check(capData.size() == b + 3, "R12", "one frame per handshake",
          capData.size(), b + 3);
    expectFrame(b, 8'hF0, "R12");
    expectFrame(b + 1, 8'h0F, "R12");
    expectFrame(b + 2, 8'h80, "R12");
  endtask

  initial begin
    t_reset_r1();
    t_basic_r2();
    t_parity_r3();
    t_cts_r4();
    t_cts_off_r5();
    t_xoff_r6();
    t_midframe_r7();
    t_ctrl_first_r8();
    t_ctrl_paused_r9();
    t_swoff_r10();
    t_both_r11();
    t_handshake_r12();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule